// File: doc/BRIEF.md
# Return-from-Interrupt Machine State Restore

This combinational block produces the machine state register value and the resume address that take effect when an interrupt handler returns. It takes three inputs: the live machine state word, the state word saved when the interrupt was taken, and the saved return address. Bits are numbered MSB-0, so bit 0 is the most significant bit of the 64-bit word.

The new state is not a plain copy of the saved word. Each bit is assigned to one class:
- taken from the saved word;
- held at its live value;
- set by a guarded rule.

The guarded rules protect the hypervisor bit, gate machine-check enable on hypervisor mode, and stop a saved all-zero transaction-state field from overwriting one particular live transaction state. The resume address is the saved address with its low bits cleared, so it is word aligned.

The block sits in the execute stage beside the trap logic. Its outputs are written back when the instruction retires. Checking whether the instruction is allowed, and fetching from the resume address, are done elsewhere.

Top module: `rfi_msr_restore`

## Requirements
- R1: New bit 3 (hypervisor) is the AND of live bit 3 and saved bit 3.
- R2: When live bit 3 is 1, new bit 51 (machine-check enable) equals saved bit 51.
- R3: When live bit 3 is 0, new bit 51 equals live bit 51.
- R4: New bits 29..31 equal saved bits 29..31 unless the guard case of R5 holds.
- R5: When live bits 29..31 are 0b010 and saved bits 29..31 are 0b000, new bits 29..31 stay 0b010.
- R6: New bits 48, 58 and 59 (interrupt enable, instruction and data translation) equal the saved bits.
- R7: New bits 0..2, 4..28, 32, 37..41, 49..50, 52..57 and 60..63 equal the saved bits.
- R8: New bits 33..36 and 42..47 equal the live bits.
- R9: The resume address equals the saved address with its two least significant bits forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| msr_i | input | 64 | Live machine state word, MSB-0 numbering |
| srr1_i | input | 64 | Machine state word saved at interrupt entry |
| srr0_i | input | 64 | Saved return address |
| msr_o | output | 64 | Restored machine state word |
| nia_o | output | 64 | Word-aligned resume address |

## Verification
The bench builds the block with its default parameters:
- a 64-bit state word;
- a 64-bit address;
- two alignment bits;
- the hypervisor, machine-check and transaction-state positions at 3, 51 and 29..31.

With these values, the directed vectors run all eight combinations of live hypervisor, live guard pattern and saved guard pattern. Seeded random pairs, biased toward the guard encodings, then exercise every bit class against an independent bit-level model.

// File: rtl/rfi_pkg.sv
`timescale 1ns/1ps
package rfi_pkg;

  typedef enum logic [2:0] {
    SRC_SAVED,
    SRC_LIVE,
    SRC_HV,
    SRC_ME,
    SRC_TS
  } rfi_src_e;

  // classify one MSB-0 bit position
  function automatic rfi_src_e bit_src(int b, int hv_b, int me_b, int ts_b, int ts_w,
                                       int ka_lo, int ka_hi, int kb_lo, int kb_hi);
    if (b == hv_b) return SRC_HV;
    if (b == me_b) return SRC_ME;
    if (b >= ts_b && b < ts_b + ts_w) return SRC_TS;
    if ((b >= ka_lo && b <= ka_hi) || (b >= kb_lo && b <= kb_hi)) return SRC_LIVE;
    return SRC_SAVED;
  endfunction

endpackage

// File: rtl/rfi_hv_me.sv
`timescale 1ns/1ps
module rfi_hv_me (
  input  logic cur_hv_i,
  input  logic cur_me_i,
  input  logic sav_hv_i,
  input  logic sav_me_i,
  output logic new_hv_o,
  output logic new_me_o
);
  // hypervisor state can only be dropped, never raised, by the saved word
  assign new_hv_o = cur_hv_i & sav_hv_i;
  assign new_me_o = cur_hv_i ? sav_me_i : cur_me_i;
endmodule

// File: rtl/rfi_ts_guard.sv
`timescale 1ns/1ps
module rfi_ts_guard #(
  parameter int          TS_W      = 3,
  parameter logic [TS_W-1:0] GUARD_CUR = 3'b010,
  parameter logic [TS_W-1:0] GUARD_SAV = 3'b000
) (
  input  logic [TS_W-1:0] cur_i,
  input  logic [TS_W-1:0] sav_i,
  output logic [TS_W-1:0] new_o
);
  logic hold;
  assign hold  = (cur_i == GUARD_CUR) && (sav_i == GUARD_SAV);
  assign new_o = hold ? cur_i : sav_i;
endmodule

// File: rtl/rfi_nia_align.sv
`timescale 1ns/1ps
module rfi_nia_align #(
  parameter int AW         = 64,
  parameter int ALIGN_BITS = 2
) (
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  assign addr_o = {addr_i[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/rfi_msr_restore.sv
`timescale 1ns/1ps
module rfi_msr_restore
  import rfi_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int AW         = 64,
  parameter int ALIGN_BITS = 2,
  parameter int HV_BIT     = 3,
  parameter int ME_BIT     = 51,
  parameter int TS_BIT     = 29,
  parameter int TS_W       = 3,
  parameter int KA_LO      = 33,
  parameter int KA_HI      = 36,
  parameter int KB_LO      = 42,
  parameter int KB_HI      = 47
) (
  input  logic [XLEN-1:0] msr_i,
  input  logic [XLEN-1:0] srr1_i,
  input  logic [AW-1:0]   srr0_i,
  output logic [XLEN-1:0] msr_o,
  output logic [AW-1:0]   nia_o
);
  // MSB-0 position -> vector index
  localparam int HV_L    = XLEN - 1 - HV_BIT;
  localparam int ME_L    = XLEN - 1 - ME_BIT;
  localparam int TS_HI_L = XLEN - 1 - TS_BIT;
  localparam int TS_LO_L = XLEN - TS_BIT - TS_W;

  logic            hv_new, me_new;
  logic [TS_W-1:0] ts_new;
  logic [XLEN-1:0] live_m, saved_m;

  rfi_hv_me i_hv_me (
    .cur_hv_i (msr_i[HV_L]),
    .cur_me_i (msr_i[ME_L]),
    .sav_hv_i (srr1_i[HV_L]),
    .sav_me_i (srr1_i[ME_L]),
    .new_hv_o (hv_new),
    .new_me_o (me_new)
  );

  rfi_ts_guard #(.TS_W(TS_W)) i_ts_guard (
    .cur_i (msr_i[TS_HI_L:TS_LO_L]),
    .sav_i (srr1_i[TS_HI_L:TS_LO_L]),
    .new_o (ts_new)
  );

  rfi_nia_align #(.AW(AW), .ALIGN_BITS(ALIGN_BITS)) i_nia_align (
    .addr_i (srr0_i),
    .addr_o (nia_o)
  );

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    localparam rfi_src_e SRC = bit_src(XLEN - 1 - i, HV_BIT, ME_BIT, TS_BIT, TS_W,
                                       KA_LO, KA_HI, KB_LO, KB_HI);
    assign live_m[i]  = (SRC == SRC_LIVE);
    assign saved_m[i] = (SRC == SRC_SAVED);
    if (SRC == SRC_HV) begin : g_hv
      assign msr_o[i] = hv_new;
    end else if (SRC == SRC_ME) begin : g_me
      assign msr_o[i] = me_new;
    end else if (SRC == SRC_TS) begin : g_ts
      assign msr_o[i] = ts_new[i - TS_LO_L];
    end else if (SRC == SRC_LIVE) begin : g_live
      assign msr_o[i] = msr_i[i];
    end else begin : g_sav
      assign msr_o[i] = srr1_i[i];
    end
  end

  localparam logic [AW-1:0] LOW_M = AW'((1 << ALIGN_BITS) - 1);

  always_comb begin
    p_hv_drop_r1: assert (msr_o[HV_L] == (msr_i[HV_L] & srr1_i[HV_L]))
      else $error("hv restore");
    if (msr_i[HV_L]) begin
      p_me_saved_r2: assert (msr_o[ME_L] == srr1_i[ME_L]) else $error("me from saved");
    end else begin
      p_me_live_r3: assert (msr_o[ME_L] == msr_i[ME_L]) else $error("me held");
    end
    if (msr_i[TS_HI_L:TS_LO_L] == 3'b010 && srr1_i[TS_HI_L:TS_LO_L] == 3'b000) begin
      p_ts_guard_r5: assert (msr_o[TS_HI_L:TS_LO_L] == 3'b010) else $error("ts guard");
    end else begin
      p_ts_load_r4: assert (msr_o[TS_HI_L:TS_LO_L] == srr1_i[TS_HI_L:TS_LO_L])
        else $error("ts load");
    end
    p_saved_copy_r7: assert ((msr_o & saved_m) == (srr1_i & saved_m)) else $error("copy");
    p_live_keep_r8: assert ((msr_o & live_m) == (msr_i & live_m)) else $error("keep");
    p_nia_align_r9: assert (((nia_o & LOW_M) == '0) && ((nia_o | LOW_M) == (srr0_i | LOW_M)))
      else $error("nia align");
  end

endmodule

// File: tb/test_rfi_msr_restore.sv
`timescale 1ns/1ps
module test_rfi_msr_restore;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] msr_i, srr1_i, srr0_i, msr_o, nia_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  rfi_msr_restore i_rfi_msr_restore (
    .msr_i (msr_i), .srr1_i (srr1_i), .srr0_i (srr0_i),
    .msr_o (msr_o), .nia_o (nia_o)
  );

  function automatic int ix(int b); return 63 - b; endfunction

  function automatic logic [63:0] rng(int lo, int hi);
    logic [63:0] m = '0;
    for (int b = lo; b <= hi; b++) m[ix(b)] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] ref_msr(logic [63:0] cur, logic [63:0] sav);
    logic [63:0] r = sav;
    logic [2:0] ct, st;
    r[ix(3)]  = cur[ix(3)] & sav[ix(3)];
    r[ix(51)] = cur[ix(3)] ? sav[ix(51)] : cur[ix(51)];
    ct = {cur[ix(29)], cur[ix(30)], cur[ix(31)]};
    st = {sav[ix(29)], sav[ix(30)], sav[ix(31)]};
    if (ct == 3'b010 && st == 3'b000) begin
      r[ix(29)] = ct[2]; r[ix(30)] = ct[1]; r[ix(31)] = ct[0];
    end
    for (int b = 33; b <= 36; b++) r[ix(b)] = cur[ix(b)];
    for (int b = 42; b <= 47; b++) r[ix(b)] = cur[ix(b)];
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [63:0] m, logic [63:0] s, logic [63:0] a);
    logic [63:0] e, m7, m6, mts;
    @(negedge clk);
    msr_i = m; srr1_i = s; srr0_i = a;
    #1;
    e   = ref_msr(m, s);
    m6  = rng(48, 48) | rng(58, 59);
    m7  = rng(0, 2) | rng(4, 28) | rng(32, 32) | rng(37, 41) | rng(49, 50)
        | rng(52, 57) | rng(60, 63);
    mts = rng(29, 31);
    check("R1", 64'(msr_o[ix(3)]), 64'(e[ix(3)]));
    if (m[ix(3)]) check("R2", 64'(msr_o[ix(51)]), 64'(s[ix(51)]));
    else          check("R3", 64'(msr_o[ix(51)]), 64'(m[ix(51)]));
    if ((m & mts) == rng(30, 30) && (s & mts) == '0) check("R5", msr_o & mts, rng(30, 30));
    else check("R4", msr_o & mts, s & mts);
    check("R6", msr_o & m6, s & m6);
    check("R7", msr_o & m7, s & m7);
    check("R8", msr_o & (rng(33, 36) | rng(42, 47)), m & (rng(33, 36) | rng(42, 47)));
    check("R9", nia_o, {a[63:2], 2'b00});
    check("R1-model", msr_o, e);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] set_ts(logic [63:0] v, logic [2:0] t);
    v[ix(29)] = t[2]; v[ix(30)] = t[1]; v[ix(31)] = t[0];
    return v;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    msr_i = '0; srr1_i = '0; srr0_i = '0;
    // all-zero start state
    apply('0, '0, '0);
    apply('1, '1, '1);
    apply('1, '0, 64'h3);
    apply('0, '1, 64'hffff_ffff_ffff_fffd);
    // every HV x live guard x saved guard combination
    for (int c = 0; c < 8; c++) begin
      logic [63:0] m = r64(), s = r64();
      m[ix(3)] = c[2];
      m = set_ts(m, c[1] ? 3'b010 : 3'b110);
      s = set_ts(s, c[0] ? 3'b000 : 3'b001);
      apply(m, s, r64());
    end
    for (int n = 0; n < 400; n++) begin
      logic [63:0] m = r64(), s = r64();
      if (n % 3 == 0) m = set_ts(m, 3'b010);
      if (n % 4 == 0) s = set_ts(s, 3'b000);
      apply(m, s, r64());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule